// File: doc/BRIEF.md
# Register-Triggered Link Request Launcher

This block is a small local register file that assembles a request for a transfer on a remote crate and hands it to a serial link transmitter. Software writes four configuration words. The first is a control/header word, and its low 24 bits travel on the link. The others are an address modifier, a remote address, and a data word or byte count. A select field in the header picks which of three register writes launches the request. A sequence of transfers that differ only in address or only in data can therefore be issued with a single bus write each.

When a request is launched, a one-cycle strobe presents all fields to the link side. The block then waits for a confirmation carrying a completion code. While it waits, the status register reads a fixed busy code. Once the wait ends, the status register holds either the confirmed code or a timeout code. Two header flags add actions at launch time: one clears any retained code, and one pulses a reset toward the DMA input FIFO. A write of any data to a dedicated key offset aborts the outstanding request and clears the status.

Top module: `link_req_launcher`

## Requirements
- R1: After reset, the four configuration registers read zero, the status register reads 0x000, and neither `req_valid` nor `dma_fifo_rst` is high.
- R2: The configuration registers are written and read back at byte offsets header 0x80, address modifier 0x84, address 0x88 and data/length 0x90. The status register is at 0xAC. Any other read offset returns zero.
- R3: Header bits 27:24 select the launch source. The value 0x1 launches on a header write, 0x2 on an address write and 0x4 on a data/length write. Any other value, and any address-modifier write, never launches. A launch raises `req_valid` for exactly the one cycle after the triggering write. In that cycle, `req_hdr` equals header bits 23:0, `req_am` equals the low 6 bits of the modifier, and `req_addr` and `req_data` carry the stored words, including the value of the triggering write itself.
- R4: From the cycle after a launch until the request ends, the status register reads 0x005.
- R5: A `cfm_valid` pulse while a request is outstanding ends it in that cycle's edge. Afterwards the status reads the confirmed `cfm_code`, provided no non-zero code was retained. Possible codes include 0x000 (success), 0x101, 0x103, 0x107, 0x203, 0x211, 0x212 and 0x214.
- R6: If header bit 29 is set at launch, the retained code is cleared. If it is clear, a non-zero code retained from an earlier request is kept, and the new completion code is discarded.
- R7: If header bit 28 is set at launch, `dma_fifo_rst` pulses high for one cycle, coincident with `req_valid`. Otherwise it stays low.
- R8: While a request is outstanding, triggering writes launch nothing, although the written register still takes the new value. A `cfm_valid` pulse while idle leaves the status unchanged.
- R9: If no confirmation arrives within `TMO_CYC` cycles after launch, the request ends and the status reads 0x107, unless an earlier non-zero code is retained.
- R10: A write of any data to offset 0x24 ends an outstanding request at once and sets the status to 0x000. No timeout follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data (combinational) |
| req_valid | output | 1 | One-cycle launch strobe toward the link |
| req_hdr | output | 24 | Header word sent on the link |
| req_am | output | AM_W | Remote address modifier |
| req_addr | output | DATA_W | Remote address |
| req_data | output | DATA_W | Data word or byte length |
| dma_fifo_rst | output | 1 | One-cycle reset toward the DMA input FIFO |
| cfm_valid | input | 1 | Confirmation from the link side |
| cfm_code | input | 12 | Completion code of the confirmation |

## Verification
The hardest situation to reach from the ports is a trigger write that arrives while a request is outstanding. It has to be shown launching nothing while still updating the register. The bench reaches it by launching from a header write, holding back the confirmation, and writing a fresh triggering header during the busy window. The retained-code path is similarly awkward to reach. It requires a failing completion followed by a launch without the clear flag, which the bench sets up in sequence.

The launch selection is swept over all sixteen select values against writes to all four registers. The timeout is counted out to the exact cycle with a small `TMO_CYC`.

// File: rtl/link_req_pkg.sv
// Package: register offsets, header field positions and completion codes
// shared by the launcher, its submodules and its checker.
package link_req_pkg;
    localparam int NUM_CFG  = 4;
    localparam int IDX_HDR  = 0;
    localparam int IDX_AM   = 1;
    localparam int IDX_ADR  = 2;
    localparam int IDX_DAT  = 3;
    localparam int CFG_OFS [NUM_CFG] = '{'h80, 'h84, 'h88, 'h90};
    localparam int OFS_STAT = 'hAC;
    localparam int OFS_KEY  = 'h24;

    localparam int HDR_W    = 24;
    localparam int CODE_W   = 12;

    // header control slice [29:24] as seen by the trigger logic
    localparam int CTL_CLR  = 5;   // header bit 29
    localparam int CTL_FRST = 4;   // header bit 28

    localparam logic [3:0] TRIG_ON_HDR = 4'h1;
    localparam logic [3:0] TRIG_ON_ADR = 4'h2;
    localparam logic [3:0] TRIG_ON_DAT = 4'h4;

    localparam logic [CODE_W-1:0] CODE_OK   = 12'h000;
    localparam logic [CODE_W-1:0] CODE_BUSY = 12'h005;
    localparam logic [CODE_W-1:0] CODE_TMO  = 12'h107;
endpackage

// File: rtl/lrl_regfile.sv
// Module: lrl_regfile
// Holds the four configuration words and flags which one the current bus
// write hits. Assumes one write per cycle at a byte offset; registers are
// written regardless of the launcher state.
module lrl_regfile
    import link_req_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_q [NUM_CFG],
    output logic [NUM_CFG-1:0] cfg_hit
);
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        // decode the write address for this register
        assign cfg_hit[i] = wr_en && (wr_addr == ADDR_W'(CFG_OFS[i]));

        // store the written word
        always_ff @(posedge clk) begin
            if (!rst_n)          cfg_q[i] <= '0;
            else if (cfg_hit[i]) cfg_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/lrl_trigger.sv
// Module: lrl_trigger
// Decides in the write cycle whether a request launches, and which launch
// actions apply. For a header write the select and flags come from the data
// being written; otherwise from the stored header. Pure combinational.
module lrl_trigger
    import link_req_pkg::*;
(
    input  logic [NUM_CFG-1:0] cfg_hit,
    input  logic [5:0]         wr_ctl,    // wr_data[29:24]
    input  logic [5:0]         hdr_ctl,   // stored header[29:24]
    input  logic               busy,
    output logic               launch,
    output logic               clr_code,
    output logic               fifo_rst
);
    logic [5:0] ctl;
    logic [3:0] sel;

    // pick the control bits that apply to this cycle and evaluate the trigger
    always_comb begin
        ctl    = cfg_hit[IDX_HDR] ? wr_ctl : hdr_ctl;
        sel    = ctl[3:0];
        launch = !busy && ((cfg_hit[IDX_HDR] && sel == TRIG_ON_HDR) ||
                           (cfg_hit[IDX_ADR] && sel == TRIG_ON_ADR) ||
                           (cfg_hit[IDX_DAT] && sel == TRIG_ON_DAT));
        clr_code = launch && ctl[CTL_CLR];
        fifo_rst = launch && ctl[CTL_FRST];
    end
endmodule

// File: rtl/lrl_sequencer.sv
// Module: lrl_sequencer
// Tracks the outstanding request: busy flag, confirmation timeout counter
// and the retained completion code. The first non-zero code is kept until
// cleared by a launch flag or a key reset. Assumes TMO_CYC >= 2.
module lrl_sequencer
    import link_req_pkg::*;
#(
    parameter int TMO_CYC = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              clr_code,
    input  logic              key_rst,
    input  logic              cfm_valid,
    input  logic [CODE_W-1:0] cfm_code,
    output logic              busy,
    output logic [CODE_W-1:0] code_q
);
    localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;

    // request state: launch, confirmation, timeout, key reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
            code_q   <= CODE_OK;
        end else if (key_rst) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
            code_q   <= CODE_OK;
        end else if (busy) begin
            if (cfm_valid) begin
                busy <= 1'b0;
                if (code_q == CODE_OK) code_q <= cfm_code;
            end else if (wait_cnt == CNT_LAST) begin
                busy <= 1'b0;
                if (code_q == CODE_OK) code_q <= CODE_TMO;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end else if (launch) begin
            busy     <= 1'b1;
            wait_cnt <= '0;
            if (clr_code) code_q <= CODE_OK;
        end
    end
endmodule

// File: rtl/link_req_launcher.sv
// Module: link_req_launcher (top)
// Register-triggered launcher of remote transfer requests. Builds the
// request from four configuration words, launches it on the write chosen by
// the header select field, and reports busy / completion through a status
// register. Assumes a single-cycle register write port and a combinational
// read port; the link side accepts req_valid without back-pressure.
module link_req_launcher
    import link_req_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int AM_W    = 6,
    parameter int TMO_CYC = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              req_valid,
    output logic [HDR_W-1:0]  req_hdr,
    output logic [AM_W-1:0]   req_am,
    output logic [DATA_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              dma_fifo_rst,
    input  logic              cfm_valid,
    input  logic [CODE_W-1:0] cfm_code
);
    logic [DATA_W-1:0]  cfg_q [NUM_CFG];
    logic [NUM_CFG-1:0] cfg_hit;
    logic               launch;
    logic               clr_code;
    logic               fifo_rst;
    logic               busy;
    logic               key_rst;
    logic [CODE_W-1:0]  code_q;

    lrl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .cfg_hit (cfg_hit)
    );

    lrl_trigger u_trig (
        .cfg_hit  (cfg_hit),
        .wr_ctl   (wr_data[29:24]),
        .hdr_ctl  (cfg_q[IDX_HDR][29:24]),
        .busy     (busy),
        .launch   (launch),
        .clr_code (clr_code),
        .fifo_rst (fifo_rst)
    );

    // key offset write of any data resets the request logic
    assign key_rst = wr_en && (wr_addr == ADDR_W'(OFS_KEY));

    lrl_sequencer #(.TMO_CYC(TMO_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .clr_code  (clr_code),
        .key_rst   (key_rst),
        .cfm_valid (cfm_valid),
        .cfm_code  (cfm_code),
        .busy      (busy),
        .code_q    (code_q)
    );

    // one-cycle strobes following the triggering write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid    <= 1'b0;
            dma_fifo_rst <= 1'b0;
        end else begin
            req_valid    <= launch;
            dma_fifo_rst <= fifo_rst;
        end
    end

    // request fields come straight from the stored words
    assign req_hdr  = cfg_q[IDX_HDR][HDR_W-1:0];
    assign req_am   = cfg_q[IDX_AM][AM_W-1:0];
    assign req_addr = cfg_q[IDX_ADR];
    assign req_data = cfg_q[IDX_DAT];

    // read multiplexer over configuration and status
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (rd_addr == ADDR_W'(CFG_OFS[i])) rd_data = cfg_q[i];
        if (rd_addr == ADDR_W'(OFS_STAT))
            rd_data = busy ? DATA_W'(CODE_BUSY) : DATA_W'(code_q);
    end
endmodule

// File: rtl/lrl_checker.sv
// Module: lrl_checker
// Property checks on the launcher, attached by bind. Keeps its own busy
// cycle counter so the timeout window is checked without deep $past.
module lrl_checker
    import link_req_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int TMO_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              launch,
    input logic              key_rst,
    input logic              req_valid,
    input logic              dma_fifo_rst,
    input logic              cfm_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    int unsigned busy_cyc;

    // count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= 0;
        else                 busy_cyc <= busy_cyc + 1;
    end

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);
    a_r4_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_addr == ADDR_W'(OFS_STAT)) |-> rd_data == DATA_W'(CODE_BUSY));
    a_r5_cfm_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfm_valid) |=> !busy);
    a_r7_fifo_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dma_fifo_rst |-> req_valid);
    a_r8_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);
    a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cyc < TMO_CYC);
    a_r10_key_idle: assert property (@(posedge clk) disable iff (!rst_n)
        key_rst |=> !busy);
endmodule

bind link_req_launcher lrl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .launch       (launch),
    .key_rst      (key_rst),
    .req_valid    (req_valid),
    .dma_fifo_rst (dma_fifo_rst),
    .cfm_valid    (cfm_valid),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data)
);

// File: tb/link_req_launcher_tb.sv
`timescale 1ns/1ps
module link_req_launcher_tb;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        req_valid;
    logic [23:0] req_hdr;
    logic [5:0]  req_am;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic        dma_fifo_rst;
    logic        cfm_valid = 1'b0;
    logic [11:0] cfm_code = '0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    link_req_launcher #(.TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_valid(req_valid), .req_hdr(req_hdr), .req_am(req_am),
        .req_addr(req_addr), .req_data(req_data), .dma_fifo_rst(dma_fifo_rst),
        .cfm_valid(cfm_valid), .cfm_code(cfm_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write one register; returns at the negedge after the capturing edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic confirm(input logic [11:0] c);
        @(negedge clk);
        cfm_valid = 1'b1; cfm_code = c;
        @(negedge clk);
        cfm_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_hdr(input logic clr, input logic frst,
                                           input logic [3:0] trig, input logic [23:0] body);
        return {2'b00, clr, frst, trig, body};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] codes [8] = '{12'h000, 12'h101, 12'h103, 12'h107,
                                    12'h203, 12'h211, 12'h212, 12'h214};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_valid", {31'b0, req_valid}, 0);
        chk("R1 dma_fifo_rst", {31'b0, dma_fifo_rst}, 0);
        for (int i = 0; i < 4; i++) begin
            rd(12'h80 + 12'(4 * i + (i == 3 ? 4 : 0)), v);
            chk("R1 cfg zero", v, 0);
        end
        rd(12'hAC, v); chk("R1 status zero", v, 0);

        // R2 write/readback with select 0 (no launch)
        wr(12'h80, mk_hdr(0, 0, 4'h0, 24'h13579B));
        wr(12'h84, 32'h0000_002D);
        wr(12'h88, 32'hCAFE_0010);
        wr(12'h90, 32'h0BAD_F00D);
        rd(12'h80, v); chk("R2 hdr", v, mk_hdr(0, 0, 4'h0, 24'h13579B));
        rd(12'h84, v); chk("R2 am", v, 32'h2D);
        rd(12'h88, v); chk("R2 adr", v, 32'hCAFE_0010);
        rd(12'h90, v); chk("R2 dat", v, 32'h0BAD_F00D);
        rd(12'h8C, v); chk("R2 hole", v, 0);
        rd(12'h24, v); chk("R2 key reads zero", v, 0);

        // R3 sweep: every select value against every register write
        for (int t = 0; t < 16; t++) begin
            logic [31:0] h, a, d;
            logic [5:0]  m;
            h = mk_hdr(1, 0, 4'(t), 24'h5A0000 | 24'(t));
            m = 6'(9 + t);
            a = 32'h1000_0000 + 32'(t * 4);
            d = 32'hD000_0000 + 32'(t);
            wr(12'h80, h);
            chk("R3 launch on hdr", {31'b0, req_valid}, {31'b0, t == 1});
            chk("R7 no fifo rst", {31'b0, dma_fifo_rst}, 0);
            if (t == 1) begin
                chk("R3 req_hdr", {8'b0, req_hdr}, {8'b0, h[23:0]});
                confirm(12'h000);
            end
            wr(12'h84, {26'b0, m});
            chk("R3 am never launches", {31'b0, req_valid}, 0);
            wr(12'h88, a);
            chk("R3 launch on adr", {31'b0, req_valid}, {31'b0, t == 2});
            if (t == 2) begin
                chk("R3 req_addr", req_addr, a);
                chk("R3 req_am", {26'b0, req_am}, {26'b0, m});
                chk("R3 req_hdr adr", {8'b0, req_hdr}, {8'b0, h[23:0]});
                confirm(12'h000);
            end
            wr(12'h90, d);
            chk("R3 launch on dat", {31'b0, req_valid}, {31'b0, t == 4});
            if (t == 4) begin
                chk("R3 req_data", req_data, d);
                confirm(12'h000);
            end
            @(negedge clk);
            chk("R3 strobe one cycle", {31'b0, req_valid}, 0);
        end

        // R4 and R5: busy code then each completion code
        foreach (codes[k]) begin
            wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000100));
            rd(12'hAC, v); chk("R4 busy", v, 32'h005);
            @(negedge clk);
            rd(12'hAC, v); chk("R4 busy held", v, 32'h005);
            confirm(codes[k]);
            rd(12'hAC, v); chk("R5 completion code", v, {20'b0, codes[k]});
        end

        // R6 retained code without clear flag, replaced with clear flag
        wr(12'h80, mk_hdr(0, 0, 4'h1, 24'h000200));
        confirm(12'h101);
        rd(12'hAC, v); chk("R6 retained", v, 32'h214);
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000200));
        confirm(12'h101);
        rd(12'hAC, v); chk("R6 cleared then new", v, 32'h101);

        // R7 fifo reset flag
        wr(12'h80, mk_hdr(1, 1, 4'h1, 24'h000300));
        chk("R7 req_valid", {31'b0, req_valid}, 1);
        chk("R7 fifo rst pulse", {31'b0, dma_fifo_rst}, 1);
        @(negedge clk);
        chk("R7 fifo rst one cycle", {31'b0, dma_fifo_rst}, 0);
        confirm(12'h000);

        // R8 triggering write while busy; confirmation while idle
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000400));
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000777));
        chk("R8 no launch while busy", {31'b0, req_valid}, 0);
        rd(12'h80, v); chk("R8 hdr still stored", v, mk_hdr(1, 0, 4'h1, 24'h000777));
        rd(12'hAC, v); chk("R8 still busy", v, 32'h005);
        confirm(12'h000);
        confirm(12'h203);
        rd(12'hAC, v); chk("R8 idle cfm ignored", v, 0);

        // R9 timeout counted to the cycle
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000500));
        repeat (TMO - 1) @(negedge clk);
        rd(12'hAC, v); chk("R9 busy before expiry", v, 32'h005);
        @(negedge clk);
        rd(12'hAC, v); chk("R9 timeout code", v, 32'h107);

        // R10 key reset aborts the request
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000600));
        wr(12'h24, 32'hDEAD_BEEF);
        rd(12'hAC, v); chk("R10 key clears", v, 0);
        repeat (TMO + 4) @(negedge clk);
        rd(12'hAC, v); chk("R10 no late timeout", v, 0);
        wr(12'h80, mk_hdr(1, 0, 4'h1, 24'h000601));
        chk("R10 relaunch ok", {31'b0, req_valid}, 1);
        confirm(12'h000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule